// File: doc/BRIEF.md
# Binary32 Floating-Point Multiplier

This block multiplies two single-precision (binary32) floating-point numbers in a two-stage pipeline. Each operand packs a sign in bit 31, an 8-bit biased exponent in bits 30:23 (bias 127) and a 23-bit fraction in bits 22:0. For a normal operand, the 24-bit significand is the fraction with a leading 1 placed in front of it.

The first stage decodes both operands and sorts the pair into one of four kinds: ordinary number, zero, infinity or invalid. It also forms the exponent sum minus the bias and multiplies the two significands into a 48-bit product. The second stage normalizes that product. It then rounds to nearest, with ties going to even, using the guard, round and sticky bits below the kept precision. If rounding carries out of the significand, it renormalizes. Only after rounding does it check the exponent range, and it raises one of three status flags if needed.

A new operand pair can be accepted on every cycle. Denormal inputs count as zero, and results too small for a normal encoding are flushed to zero. Typical use is inside an arithmetic unit that issues a product every cycle and picks up the result two cycles later.

Top module: `fp32_mul_unit`

## Requirements
- R1: A pair accepted with `inValid` high at clock edge k gives `outValid` high, together with its result and flags, after edge k+1 and for that one cycle only. Pairs may be accepted on consecutive cycles, and results leave in the same order.
- R2: Every result that is not NaN carries a sign equal to the XOR of the two operand signs.
- R3: For two normal operands, the result exponent is expA + expB - 127, plus 1 when the significand product is 2.0 or more. The kept 23 fraction bits follow the leading 1 of the normalized product.
- R4: The product is rounded to nearest. Guard = 1 with round or sticky set rounds up. Guard = 0 truncates. An exact tie (guard 1, all lower bits 0) rounds up only when the kept LSB is 1.
- R5: When rounding carries out of a significand that is all ones, the fraction becomes 0 and the exponent goes up by 1.
- R6: If either operand is NaN (exponent 255, fraction not 0), or the pair is zero times infinity, the result is 0x7FC00000 and `flagInvalid` is 1. No other NaN encoding is ever produced.
- R7: A rounded exponent of 255 or more gives a signed infinity (exponent 255, fraction 0) and sets `flagOverflow`. Exponent 254 with all fraction bits set is still a normal result, with no flag.
- R8: A rounded exponent of 0 or less gives a signed zero and sets `flagUnderflow`. Rounding that lifts the exponent to 1 gives the normal result with no flag.
- R9: An operand with exponent 0 (zero or denormal) times a finite operand gives a signed zero with no flag.
- R10: Infinity times a nonzero finite number, or infinity times infinity, gives a signed infinity with no flag.
- R11: At most one of the three flags is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand pair present this cycle |
| opA | input | 32 | First binary32 operand |
| opB | input | 32 | Second binary32 operand |
| outValid | output | 1 | Result and flags are valid |
| result | output | 32 | Binary32 product |
| flagOverflow | output | 1 | Result overflowed to infinity |
| flagUnderflow | output | 1 | Result flushed to zero |
| flagInvalid | output | 1 | Invalid operation, canonical NaN returned |

## Verification
Two functions can act on the same operation: the rounding carry and the exponent range check. A carry out of an all-ones significand moves the exponent by one, so it can push a result across either range boundary. The bench provokes this with significand pairs whose product lies just under 2.0 by less than half an ulp. One pair has its exponent sum at 254, where the carry must produce infinity with overflow. The other has its sum at 0, where the carry must rescue a normal 0x00800000 with no flag. Each case is judged on the exact result word and on all three flags, next to neighbouring cases that stay just inside the range.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int EXT_W   = EXP_W + 2;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;

  typedef enum logic [1:0] {
    KIND_NUM,
    KIND_ZERO,
    KIND_INF,
    KIND_NAN
  } fpmKind_t;

  typedef struct packed {
    logic loadIssue;
    logic loadFinish;
  } fpmStrobes_t;
endpackage

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  output fpmStrobes_t strobes,
  output logic        outValid
);
  logic stageOneValid;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageOneValid <= 1'b0;
      outValid      <= 1'b0;
    end else begin
      stageOneValid <= inValid;
      outValid      <= stageOneValid;
    end
  end

  always_comb begin
    strobes.loadIssue  = inValid;
    strobes.loadFinish = stageOneValid;
  end

  // R1: the valid bit advances one stage per clock
  assert_issue_tracked_R1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> stageOneValid);
  assert_finish_follows_R1: assert property (@(posedge clk) disable iff (!rstN)
    stageOneValid |=> outValid);
  assert_no_spurious_valid_R1: assert property (@(posedge clk) disable iff (!rstN)
    !stageOneValid |=> !outValid);
endmodule

// File: rtl/fpm_datapath.sv
module fpm_datapath
  import fpm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  fpmStrobes_t       strobes,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] result,
  output logic              flagOverflow,
  output logic              flagUnderflow,
  output logic              flagInvalid
);
  localparam logic signed [EXT_W-1:0] BIAS_X    = EXT_W'(BIAS);
  localparam logic signed [EXT_W-1:0] TOP_X     = EXT_W'(EXP_MAX);
  localparam logic signed [EXT_W-1:0] ONE_X     = EXT_W'(1);
  localparam logic [WORD_W-1:0]       QNAN      = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
  localparam logic [WORD_W-2:0]       INF_MAG   = {{EXP_W{1'b1}}, {FRAC_W{1'b0}}};

  // ---------------- stage one: decode, exponent sum, significand product
  logic [EXP_W-1:0]  expA, expB;
  logic [FRAC_W-1:0] fracA, fracB;
  logic aZero, bZero, aInf, bInf, aNan, bNan;
  fpmKind_t          kindNow;
  logic signed [EXT_W-1:0] expSum;
  logic [PROD_W-1:0] prodNow;

  assign expA  = opA[WORD_W-2 -: EXP_W];
  assign expB  = opB[WORD_W-2 -: EXP_W];
  assign fracA = opA[FRAC_W-1:0];
  assign fracB = opB[FRAC_W-1:0];
  assign aZero = (expA == '0);
  assign bZero = (expB == '0);
  assign aInf  = (expA == '1) && (fracA == '0);
  assign bInf  = (expB == '1) && (fracB == '0);
  assign aNan  = (expA == '1) && (fracA != '0);
  assign bNan  = (expB == '1) && (fracB != '0);

  always_comb begin
    if (aNan || bNan || (aZero && bInf) || (aInf && bZero)) kindNow = KIND_NAN;
    else if (aInf || bInf)                                  kindNow = KIND_INF;
    else if (aZero || bZero)                                kindNow = KIND_ZERO;
    else                                                    kindNow = KIND_NUM;
  end

  assign expSum  = $signed({2'b00, expA}) + $signed({2'b00, expB}) - BIAS_X;
  assign prodNow = {1'b1, fracA} * {1'b1, fracB};

  fpmKind_t                s1Kind;
  logic                    s1Sign;
  logic signed [EXT_W-1:0] s1Exp;
  logic [PROD_W-1:0]       s1Prod;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Kind <= KIND_ZERO;
      s1Sign <= 1'b0;
      s1Exp  <= '0;
      s1Prod <= '0;
    end else if (strobes.loadIssue) begin
      s1Kind <= kindNow;
      s1Sign <= opA[WORD_W-1] ^ opB[WORD_W-1];
      s1Exp  <= expSum;
      s1Prod <= prodNow;
    end
  end

  // ---------------- stage two: normalize, round, range check
  logic                    prodHigh;
  logic [PROD_W-1:0]       aligned;
  logic [SIG_W-1:0]        keptSig;
  logic                    guardBit, roundBit, stickyBit, roundUp, carryOut;
  logic [SIG_W:0]          roundedSig;
  logic signed [EXT_W-1:0] normExp, finalExp;
  logic [FRAC_W-1:0]       finalFrac;
  logic [WORD_W-1:0]       nextResult;
  logic                    nextOvf, nextUnf, nextInv;

  assign prodHigh   = s1Prod[PROD_W-1];
  assign aligned    = prodHigh ? s1Prod : (s1Prod << 1);
  assign keptSig    = aligned[PROD_W-1 -: SIG_W];
  assign guardBit   = aligned[PROD_W-SIG_W-1];
  assign roundBit   = aligned[PROD_W-SIG_W-2];
  assign stickyBit  = |aligned[PROD_W-SIG_W-3:0];
  assign roundUp    = guardBit && (roundBit || stickyBit || keptSig[0]);
  assign roundedSig = {1'b0, keptSig} + {{SIG_W{1'b0}}, roundUp};
  assign carryOut   = roundedSig[SIG_W];
  assign normExp    = s1Exp + $signed({{(EXT_W-1){1'b0}}, prodHigh});
  assign finalExp   = normExp + $signed({{(EXT_W-1){1'b0}}, carryOut});
  assign finalFrac  = carryOut ? '0 : roundedSig[FRAC_W-1:0];

  always_comb begin
    nextOvf    = 1'b0;
    nextUnf    = 1'b0;
    nextInv    = 1'b0;
    nextResult = '0;
    unique case (s1Kind)
      KIND_NAN: begin
        nextResult = QNAN;
        nextInv    = 1'b1;
      end
      KIND_INF:  nextResult = {s1Sign, INF_MAG};
      KIND_ZERO: nextResult = {s1Sign, {(WORD_W-1){1'b0}}};
      default: begin
        if (finalExp >= TOP_X) begin
          nextResult = {s1Sign, INF_MAG};
          nextOvf    = 1'b1;
        end else if (finalExp < ONE_X) begin
          nextResult = {s1Sign, {(WORD_W-1){1'b0}}};
          nextUnf    = 1'b1;
        end else begin
          nextResult = {s1Sign, finalExp[EXP_W-1:0], finalFrac};
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result        <= '0;
      flagOverflow  <= 1'b0;
      flagUnderflow <= 1'b0;
      flagInvalid   <= 1'b0;
    end else if (strobes.loadFinish) begin
      result        <= nextResult;
      flagOverflow  <= nextOvf;
      flagUnderflow <= nextUnf;
      flagInvalid   <= nextInv;
    end
  end

  assert_sign_xor_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadFinish && s1Kind != KIND_NAN) |=> result[WORD_W-1] == $past(s1Sign));
  assert_invalid_canon_R6: assert property (@(posedge clk) disable iff (!rstN)
    flagInvalid |-> result == QNAN);
  assert_only_canon_nan_R6: assert property (@(posedge clk) disable iff (!rstN)
    (result[WORD_W-2 -: EXP_W] == '1 && result[FRAC_W-1:0] != '0) |-> flagInvalid);
  assert_overflow_inf_R7: assert property (@(posedge clk) disable iff (!rstN)
    flagOverflow |-> result[WORD_W-2:0] == INF_MAG);
  assert_underflow_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    flagUnderflow |-> result[WORD_W-2:0] == '0);
  assert_single_flag_R11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({flagOverflow, flagUnderflow, flagInvalid}));
endmodule

// File: rtl/fp32_mul_unit.sv
module fp32_mul_unit
  import fpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic        outValid,
  output logic [31:0] result,
  output logic        flagOverflow,
  output logic        flagUnderflow,
  output logic        flagInvalid
);
  fpmStrobes_t strobes;

  fpm_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .outValid (outValid)
  );

  fpm_datapath uPath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .opA           (opA),
    .opB           (opB),
    .result        (result),
    .flagOverflow  (flagOverflow),
    .flagUnderflow (flagUnderflow),
    .flagInvalid   (flagInvalid)
  );
endmodule

// File: tb/tb_fp32_mul_unit.sv
module tb_fp32_mul_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        outValid;
  logic [31:0] result;
  logic        flagOverflow, flagUnderflow, flagInvalid;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // flag triple is {overflow, underflow, invalid}
  localparam logic [2:0] F_NONE = 3'b000;
  localparam logic [2:0] F_OVF  = 3'b100;
  localparam logic [2:0] F_UNF  = 3'b010;
  localparam logic [2:0] F_INV  = 3'b001;

  fp32_mul_unit dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .result(result), .flagOverflow(flagOverflow),
    .flagUnderflow(flagUnderflow), .flagInvalid(flagInvalid)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic expectVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expectOut(input string req, input logic [31:0] expRes, input logic [2:0] expFlags);
    expectVal({req, " valid"}, {31'b0, outValid}, 32'd1);
    expectVal({req, " result"}, result, expRes);
    expectVal({req, " flags"}, {29'b0, flagOverflow, flagUnderflow, flagInvalid}, {29'b0, expFlags});
  endtask

  task automatic runOp(input string req, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] expRes, input logic [2:0] expFlags);
    @(negedge clk);
    opA = a; opB = b; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; opA = '0; opB = '0;
    expectVal({req, " latency"}, {31'b0, outValid}, 32'd0);
    @(negedge clk);
    expectOut(req, expRes, expFlags);
  endtask

  task automatic testReset();
    expectVal("R1 reset valid", {31'b0, outValid}, 32'd0);
    expectVal("R1 reset result", result, 32'h0);
    expectVal("R11 reset flags", {29'b0, flagOverflow, flagUnderflow, flagInvalid}, 32'd0);
  endtask

  task automatic testNormal();
    runOp("R3 1.5x2", 32'h3FC00000, 32'h40000000, 32'h40400000, F_NONE);
    runOp("R3 R2 -0.5x0.4375", 32'hBF000000, 32'h3EE00000, 32'hBE600000, F_NONE);
    runOp("R3 R2 -5x2", 32'hC0A00000, 32'h40000000, 32'hC1200000, F_NONE);
  endtask

  task automatic testRounding();
    runOp("R4 tie odd up", 32'h3F800001, 32'h3FC00000, 32'h3FC00002, F_NONE);
    runOp("R4 tie even down", 32'h3F800003, 32'h3FC00000, 32'h3FC00004, F_NONE);
    runOp("R4 above half", 32'h3F800001, 32'h3FC00001, 32'h3FC00003, F_NONE);
    runOp("R4 below half", 32'h3FFFFFFF, 32'h3F800001, 32'h40000000, F_NONE);
  endtask

  task automatic testCarry();
    runOp("R5 carry renorm", 32'h3FFFFFFE, 32'h3F800001, 32'h40000000, F_NONE);
  endtask

  task automatic testOverflow();
    runOp("R7 R11 overflow", 32'h7F000000, 32'h40000000, 32'h7F800000, F_OVF);
    runOp("R7 R2 neg overflow", 32'hFF000000, 32'h40000000, 32'hFF800000, F_OVF);
    runOp("R7 R5 carry overflow", 32'h7F7FFFFE, 32'h3F800001, 32'h7F800000, F_OVF);
    runOp("R7 max normal", 32'h7F7FFFFF, 32'h3F800000, 32'h7F7FFFFF, F_NONE);
  endtask

  task automatic testUnderflow();
    runOp("R8 R11 underflow", 32'h00800000, 32'h3F000000, 32'h00000000, F_UNF);
    runOp("R8 R2 neg underflow", 32'h80800000, 32'h3F000000, 32'h80000000, F_UNF);
    runOp("R8 min normal", 32'h00800000, 32'h3F800000, 32'h00800000, F_NONE);
    runOp("R8 R5 carry rescue", 32'h00FFFFFE, 32'h3F000001, 32'h00800000, F_NONE);
  endtask

  task automatic testZero();
    runOp("R9 zero", 32'h00000000, 32'h40400000, 32'h00000000, F_NONE);
    runOp("R9 neg zero", 32'h80000000, 32'h40400000, 32'h80000000, F_NONE);
    runOp("R9 denormal", 32'h00000001, 32'hC0000000, 32'h80000000, F_NONE);
  endtask

  task automatic testInf();
    runOp("R10 inf x -2", 32'h7F800000, 32'hC0000000, 32'hFF800000, F_NONE);
    runOp("R10 inf x inf", 32'hFF800000, 32'hFF800000, 32'h7F800000, F_NONE);
  endtask

  task automatic testInvalid();
    runOp("R6 R11 inf x 0", 32'h7F800000, 32'h00000000, 32'h7FC00000, F_INV);
    runOp("R6 nan x 1", 32'h7F800001, 32'h3F800000, 32'h7FC00000, F_INV);
    runOp("R6 0 x neg nan", 32'h00000000, 32'hFFC12345, 32'h7FC00000, F_INV);
  endtask

  task automatic testStream();
    @(negedge clk);
    opA = 32'h3FC00000; opB = 32'h40000000; inValid = 1'b1;
    @(negedge clk);
    opA = 32'h7F800000; opB = 32'h00000000;
    @(negedge clk);
    expectOut("R1 stream first", 32'h40400000, F_NONE);
    opA = 32'h00800000; opB = 32'h3F000000;
    @(negedge clk);
    expectOut("R1 stream second", 32'h7FC00000, F_INV);
    inValid = 1'b0; opA = '0; opB = '0;
    @(negedge clk);
    expectOut("R1 stream third", 32'h00000000, F_UNF);
    @(negedge clk);
    expectVal("R1 stream idle", {31'b0, outValid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testNormal();
    testRounding();
    testCarry();
    testOverflow();
    testUnderflow();
    testZero();
    testInf();
    testInvalid();
    testStream();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule